// File: doc/BRIEF.md
# Segmented Multi-Queue Circular Buffer

The block holds many independent FIFO queues in one shared on-chip entry store. Software lays out each queue through a configuration port. It picks a region of the store and then a first and a last chunk inside that region. A chunk is a fixed power-of-two run of entries, so a queue's size is always a whole number of chunks. Both chunk numbers share the one region field, so no queue can span two regions. Each queue keeps a write position (tail), a read position (head) and an occupancy count. When either position moves past the final entry of the last chunk, it jumps back to the first entry of the first chunk.

The data side has one enqueue port and one dequeue port. Each carries a queue number, and both may be used in the same cycle. Dequeued data comes back one cycle after the request, marked by a valid strobe. A request that cannot be served raises an error pulse on that same next cycle. The store is split into several banks, selected by the low address bits, so successive entries of one queue fall into successive banks. Every size is a parameter. The defaults are small for simulation: 4 queues, 8-entry chunks, 4 chunks per region, 4 regions and 8 banks. Setting chunk, chunk-per-region and region widths of 5 each gives a 32768-entry store, with queues of 32 to 1024 entries.

Top module: `seg_qbuf`

## Requirements
- R1: After reset every queue reads empty and not full, `deq_valid`, `enq_err` and `deq_err` are low, and each queue is laid out as chunk 0 to chunk 0 of region 0.
- R2: Accepted entries of one queue come out in the order they went in; the entry appears on `deq_data` with `deq_valid` high in the cycle after the accepted dequeue request.
- R3: A queue configured with first chunk F and last chunk L (F <= L) holds exactly (L-F+1)*2^EPC_LG entries; its `q_full` bit rises after that many net accepted enqueues, and `q_empty` and `q_full` are never both high.
- R4: An enqueue to a queue that is full at the start of the cycle is rejected: `enq_err` pulses high in the next cycle and the queue's contents and status are unchanged.
- R5: A dequeue from a queue that is empty at the start of the cycle is rejected: `deq_err` pulses high in the next cycle, `deq_valid` stays low and the queue's state is unchanged.
- R6: Head and tail wrap from the last entry of the last chunk to the first entry of the first chunk, so a queue can stream indefinitely without touching storage of other queues.
- R7: The entry address is {region, chunk, offset}; queues that use the same chunk numbers in different regions do not disturb each other.
- R8: A configuration write to a queue makes it empty with head and tail at its first entry; an enqueue or dequeue naming that queue in the same cycle is rejected with its error pulse.
- R9: Enqueue and dequeue are served in the same cycle, on the same or different queues; fullness and emptiness are judged on the state at the start of the cycle.
- R10: The bank of an entry is its low BANK_LG address bits and the row the rest; each bank takes at most one write and one read per cycle, and consecutive entries of a queue go to consecutive banks, modulo the bank count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | log2(NUM_Q) | Queue being configured |
| cfg_region | input | REGION_LG | Region holding the queue |
| cfg_first_chunk | input | CPR_LG | First chunk of the queue within its region |
| cfg_last_chunk | input | CPR_LG | Last chunk of the queue within its region |
| enq_valid | input | 1 | Enqueue request |
| enq_qid | input | log2(NUM_Q) | Queue to write |
| enq_data | input | DATA_W | Payload to write |
| enq_err | output | 1 | Previous cycle's enqueue was rejected |
| deq_req | input | 1 | Dequeue request |
| deq_qid | input | log2(NUM_Q) | Queue to read |
| deq_valid | output | 1 | `deq_data` holds the previous cycle's dequeued entry |
| deq_data | output | DATA_W | Dequeued payload, zero when not valid |
| deq_err | output | 1 | Previous cycle's dequeue was rejected |
| q_empty | output | NUM_Q | Per-queue empty flag |
| q_full | output | NUM_Q | Per-queue full flag |

## Verification
Several traffic patterns are used. A burst fill followed by a drain exposes ordering and capacity mistakes. Overfill and overdrain attempts show whether rejected requests leave the state alone. Long streams with enqueue and dequeue in the same cycle drive a queue around its wrap point many times, while a neighbour's parked data reveals any stray write. Queues in different regions with identical chunk numbers tell a region-select fault apart from a chunk fault. Same-cycle pairs on one full or empty queue show whether the status is judged before the cycle's updates. A reconfiguration with an enqueue in the same cycle exercises the configuration priority. A long pseudo-random mix then runs against a behavioural queue model.

// File: rtl/seg_qbuf_pkg.sv
package seg_qbuf_pkg;
   // index width for a count of items, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/seg_qbuf_bank.sv
module seg_qbuf_bank #(
   parameter int ROW_LG = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_LG-1:0] wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ROW_LG-1:0] rd_row,
   output logic [DATA_W-1:0] rd_data
);
   localparam int ROWS = 2 ** ROW_LG;

   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_row] <= wr_data;
      if (rd_en) rd_data <= mem[rd_row];
   end
endmodule

// File: rtl/seg_qbuf_qctl.sv
module seg_qbuf_qctl #(
   parameter int EPC_LG    = 3,
   parameter int CPR_LG    = 2,
   parameter int REGION_LG = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_hit,
   input  logic [REGION_LG-1:0]                cfg_region,
   input  logic [CPR_LG-1:0]                   cfg_first,
   input  logic [CPR_LG-1:0]                   cfg_last,
   input  logic                                push,
   input  logic                                pop,
   output logic [REGION_LG+CPR_LG+EPC_LG-1:0]  head_addr,
   output logic [REGION_LG+CPR_LG+EPC_LG-1:0]  tail_addr,
   output logic                                is_empty,
   output logic                                is_full
);
   localparam int LOC_W = CPR_LG + EPC_LG;
   localparam int CNT_W = LOC_W + 1;

   logic [REGION_LG-1:0] region_q;
   logic [CPR_LG-1:0]    first_q, last_q;
   logic [LOC_W-1:0]     head_q, tail_q;
   logic [CNT_W-1:0]     cnt_q, cap;

   always_comb begin
      cap = CNT_W'({1'b0, last_q} - {1'b0, first_q} + 1'b1) << EPC_LG;
   end

   assign is_empty  = (cnt_q == '0);
   assign is_full   = (cnt_q == cap);
   assign head_addr = {region_q, head_q};
   assign tail_addr = {region_q, tail_q};

   function automatic logic [LOC_W-1:0] advance(input logic [LOC_W-1:0] p);
      if (p == {last_q, {EPC_LG{1'b1}}}) return {first_q, {EPC_LG{1'b0}}};
      return p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         region_q <= '0;
         first_q  <= '0;
         last_q   <= '0;
         head_q   <= '0;
         tail_q   <= '0;
         cnt_q    <= '0;
      end else if (cfg_hit) begin
         region_q <= cfg_region;
         first_q  <= cfg_first;
         last_q   <= cfg_last;
         head_q   <= {cfg_first, {EPC_LG{1'b0}}};
         tail_q   <= {cfg_first, {EPC_LG{1'b0}}};
         cnt_q    <= '0;
      end else begin
         if (push) tail_q <= advance(tail_q);
         if (pop)  head_q <= advance(head_q);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/seg_qbuf.sv
module seg_qbuf
   import seg_qbuf_pkg::*;
#(
   parameter int NUM_Q     = 4,
   parameter int DATA_W    = 16,
   parameter int EPC_LG    = 3,
   parameter int CPR_LG    = 2,
   parameter int REGION_LG = 2,
   parameter int BANK_LG   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [idx_w(NUM_Q)-1:0]    cfg_qid,
   input  logic [REGION_LG-1:0]       cfg_region,
   input  logic [CPR_LG-1:0]          cfg_first_chunk,
   input  logic [CPR_LG-1:0]          cfg_last_chunk,
   input  logic                       enq_valid,
   input  logic [idx_w(NUM_Q)-1:0]    enq_qid,
   input  logic [DATA_W-1:0]          enq_data,
   output logic                       enq_err,
   input  logic                       deq_req,
   input  logic [idx_w(NUM_Q)-1:0]    deq_qid,
   output logic                       deq_valid,
   output logic [DATA_W-1:0]          deq_data,
   output logic                       deq_err,
   output logic [NUM_Q-1:0]           q_empty,
   output logic [NUM_Q-1:0]           q_full
);
   localparam int QID_W  = idx_w(NUM_Q);
   localparam int ADDR_W = REGION_LG + CPR_LG + EPC_LG;
   localparam int NBANK  = 2 ** BANK_LG;
   localparam int ROW_LG = ADDR_W - BANK_LG;

   // elaboration-time parameter checks
   if (NUM_Q < 2 || (2 ** QID_W) != NUM_Q) begin : g_bad_numq
      $error("NUM_Q must be a power of two, at least 2");
   end
   if (BANK_LG < 1 || BANK_LG > EPC_LG) begin : g_bad_bank
      $error("BANK_LG must be between 1 and EPC_LG");
   end
   if (CPR_LG < 1 || REGION_LG < 1 || DATA_W < 1) begin : g_bad_size
      $error("CPR_LG, REGION_LG and DATA_W must be positive");
   end

   logic [NUM_Q-1:0][ADDR_W-1:0] head_v, tail_v;
   logic                         enq_ok, deq_ok;
   logic [ADDR_W-1:0]            wr_addr, rd_addr;
   logic [NBANK-1:0]             bank_we, bank_re;
   logic [DATA_W-1:0]            bank_rd [NBANK];
   logic [BANK_LG-1:0]           rd_bank_q;

   assign enq_ok  = enq_valid && !q_full[enq_qid]  && !(cfg_we && cfg_qid == enq_qid);
   assign deq_ok  = deq_req   && !q_empty[deq_qid] && !(cfg_we && cfg_qid == deq_qid);
   assign wr_addr = tail_v[enq_qid];
   assign rd_addr = head_v[deq_qid];

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      seg_qbuf_qctl #(
         .EPC_LG(EPC_LG), .CPR_LG(CPR_LG), .REGION_LG(REGION_LG)
      ) u_qctl (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_hit    (cfg_we && cfg_qid == QID_W'(q)),
         .cfg_region (cfg_region),
         .cfg_first  (cfg_first_chunk),
         .cfg_last   (cfg_last_chunk),
         .push       (enq_ok && enq_qid == QID_W'(q)),
         .pop        (deq_ok && deq_qid == QID_W'(q)),
         .head_addr  (head_v[q]),
         .tail_addr  (tail_v[q]),
         .is_empty   (q_empty[q]),
         .is_full    (q_full[q])
      );
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_we[b] = enq_ok && wr_addr[BANK_LG-1:0] == BANK_LG'(b);
      assign bank_re[b] = deq_ok && rd_addr[BANK_LG-1:0] == BANK_LG'(b);
      seg_qbuf_bank #(.ROW_LG(ROW_LG), .DATA_W(DATA_W)) u_bank (
         .clk     (clk),
         .wr_en   (bank_we[b]),
         .wr_row  (wr_addr[ADDR_W-1:BANK_LG]),
         .wr_data (enq_data),
         .rd_en   (bank_re[b]),
         .rd_row  (rd_addr[ADDR_W-1:BANK_LG]),
         .rd_data (bank_rd[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deq_valid <= 1'b0;
         enq_err   <= 1'b0;
         deq_err   <= 1'b0;
         rd_bank_q <= '0;
      end else begin
         deq_valid <= deq_ok;
         enq_err   <= enq_valid && !enq_ok;
         deq_err   <= deq_req && !deq_ok;
         rd_bank_q <= rd_addr[BANK_LG-1:0];
      end
   end

   assign deq_data = deq_valid ? bank_rd[rd_bank_q] : '0;
endmodule

// File: rtl/seg_qbuf_chk.sv
module seg_qbuf_chk #(
   parameter int NUM_Q   = 4,
   parameter int QID_W   = 2,
   parameter int ADDR_W  = 7,
   parameter int BANK_LG = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_we,
   input logic [QID_W-1:0]             cfg_qid,
   input logic                         enq_valid,
   input logic [QID_W-1:0]             enq_qid,
   input logic                         enq_ok,
   input logic                         deq_req,
   input logic [QID_W-1:0]             deq_qid,
   input logic                         enq_err,
   input logic                         deq_err,
   input logic                         deq_valid,
   input logic [NUM_Q-1:0]             q_empty,
   input logic [NUM_Q-1:0]             q_full,
   input logic [2**BANK_LG-1:0]        bank_we,
   input logic [2**BANK_LG-1:0]        bank_re,
   input logic [NUM_Q-1:0][ADDR_W-1:0] tail_v
);
   logic [BANK_LG-1:0] wbank_next;
   assign wbank_next = tail_v[enq_qid][BANK_LG-1:0] + 1'b1;

   AST_BANK_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_we)); // R10
   AST_BANK_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_re)); // R10
   AST_BANK_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      enq_ok |=> tail_v[$past(enq_qid)][BANK_LG-1:0] == $past(wbank_next)); // R10
   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && q_full[enq_qid]) |=> enq_err); // R4
   AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_req && q_empty[deq_qid]) |=> (deq_err && !deq_valid)); // R5
   AST_NEVER_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full & q_empty) == '0); // R3
   AST_DEQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_req && !q_empty[deq_qid] && !(cfg_we && cfg_qid == deq_qid)) |=> (deq_valid && !deq_err)); // R2
   AST_CFG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && enq_valid && cfg_qid == enq_qid) |=> enq_err); // R8
endmodule

bind seg_qbuf seg_qbuf_chk #(
   .NUM_Q(NUM_Q), .QID_W(QID_W), .ADDR_W(ADDR_W), .BANK_LG(BANK_LG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_qid   (cfg_qid),
   .enq_valid (enq_valid),
   .enq_qid   (enq_qid),
   .enq_ok    (enq_ok),
   .deq_req   (deq_req),
   .deq_qid   (deq_qid),
   .enq_err   (enq_err),
   .deq_err   (deq_err),
   .deq_valid (deq_valid),
   .q_empty   (q_empty),
   .q_full    (q_full),
   .bank_we   (bank_we),
   .bank_re   (bank_re),
   .tail_v    (tail_v)
);

// File: tb/sim_seg_qbuf.sv
module sim_seg_qbuf;
   localparam int NQ = 4;
   localparam int DW = 16;
   localparam int EPC = 8;   // entries per chunk (2**EPC_LG)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_qid = '0, cfg_region = '0, cfg_first = '0, cfg_last = '0;
   logic enq_valid = 1'b0, deq_req = 1'b0;
   logic [1:0] enq_qid = '0, deq_qid = '0;
   logic [DW-1:0] enq_data = '0;
   logic enq_err, deq_err, deq_valid;
   logic [DW-1:0] deq_data;
   logic [NQ-1:0] q_empty, q_full;

   always #2.5 clk = ~clk;

   seg_qbuf u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_region(cfg_region),
      .cfg_first_chunk(cfg_first), .cfg_last_chunk(cfg_last),
      .enq_valid(enq_valid), .enq_qid(enq_qid), .enq_data(enq_data), .enq_err(enq_err),
      .deq_req(deq_req), .deq_qid(deq_qid), .deq_valid(deq_valid),
      .deq_data(deq_data), .deq_err(deq_err),
      .q_empty(q_empty), .q_full(q_full)
   );

   // behavioural reference
   typedef logic [DW-1:0] dq_t[$];
   dq_t mq[NQ];
   int  cap_m[NQ];
   logic e_enq_err, e_deq_err, e_deq_valid;
   logic [DW-1:0] e_deq_data;

   int total = 0, bad = 0;
   bit done = 1'b0;
   string tag = "R1";
   logic [DW-1:0] seq = 16'h1000;
   logic [31:0] rng = 32'h1234_5678;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit acc_e, acc_d;
      acc_e = 0; acc_d = 0;
      e_enq_err = 0; e_deq_err = 0; e_deq_valid = 0;
      if (enq_valid) begin
         if (!(cfg_we && cfg_qid == enq_qid) && mq[enq_qid].size() < cap_m[enq_qid]) acc_e = 1;
         else e_enq_err = 1;
      end
      if (deq_req) begin
         if (!(cfg_we && cfg_qid == deq_qid) && mq[deq_qid].size() > 0) acc_d = 1;
         else e_deq_err = 1;
      end
      if (acc_d) begin
         e_deq_valid = 1;
         e_deq_data  = mq[deq_qid].pop_front();
      end
      if (acc_e) mq[enq_qid].push_back(enq_data);
      if (cfg_we) begin
         mq[cfg_qid].delete();
         cap_m[cfg_qid] = (int'(cfg_last) - int'(cfg_first) + 1) * EPC;
      end
   endtask

   task automatic compare();
      logic [NQ-1:0] ee, ef;
      for (int q = 0; q < NQ; q++) begin
         ee[q] = (mq[q].size() == 0);
         ef[q] = (mq[q].size() == cap_m[q]);
      end
      chk("deq_valid", 32'(deq_valid), 32'(e_deq_valid));
      if (e_deq_valid) chk("deq_data", 32'(deq_data), 32'(e_deq_data));
      chk("enq_err", 32'(enq_err), 32'(e_enq_err));
      chk("deq_err", 32'(deq_err), 32'(e_deq_err));
      chk("q_empty", 32'(q_empty), 32'(ee));
      chk("q_full", 32'(q_full), 32'(ef));
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      model_edge();
      @(negedge clk);
      compare();
      cfg_we = 0; enq_valid = 0; deq_req = 0;
   endtask

   task automatic step(input bit ev, input int eq, input bit dv, input int dq);
      enq_valid = ev; enq_qid = 2'(eq); deq_req = dv; deq_qid = 2'(dq);
      if (ev) begin enq_data = seq; seq = seq + 16'd1; end
      tick();
   endtask

   task automatic configure(input int q, input int rg, input int f, input int l);
      cfg_we = 1; cfg_qid = 2'(q); cfg_region = 2'(rg); cfg_first = 2'(f); cfg_last = 2'(l);
      tick();
   endtask

   function automatic logic [31:0] nextrand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int q = 0; q < NQ; q++) cap_m[q] = EPC;
      e_enq_err = 0; e_deq_err = 0; e_deq_valid = 0; e_deq_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      tag = "R1";
      compare();

      // R7: layout, q0 and q2 share chunk numbers in different regions
      tag = "R8";
      configure(0, 0, 0, 0);
      configure(1, 0, 1, 3);
      configure(2, 1, 0, 0);
      configure(3, 3, 2, 3);

      // R2: ordering and one-cycle return
      tag = "R2";
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 1, 0);

      // R3 / R4: fill q0 to capacity, overfill, drain
      tag = "R3";
      for (int i = 0; i < 8; i++) step(1, 0, 0, 0);
      tag = "R4";
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      for (int i = 0; i < 8; i++) step(0, 0, 1, 0);

      // R5: dequeue from empty queues
      tag = "R5";
      step(0, 0, 1, 1);
      step(0, 0, 1, 0);

      // R7: fill q0 and q2 alternately then drain both
      tag = "R7";
      for (int i = 0; i < 8; i++) begin step(1, 0, 0, 0); step(1, 2, 0, 0); end
      for (int i = 0; i < 8; i++) begin step(0, 0, 1, 2); step(0, 0, 1, 0); end

      // R6 / R10: park data in q1, stream q3 through its wrap many times
      tag = "R6";
      for (int i = 0; i < 10; i++) step(1, 1, 0, 0);
      for (int i = 0; i < 10; i++) step(1, 3, 0, 0);
      tag = "R10";
      for (int i = 0; i < 70; i++) step(1, 3, 1, 3);
      tag = "R6";
      for (int i = 0; i < 10; i++) step(0, 0, 1, 1);
      for (int i = 0; i < 10; i++) step(0, 0, 1, 3);

      // R9: same-cycle pairs on full and empty queues, and across queues
      tag = "R9";
      for (int i = 0; i < 8; i++) step(1, 0, 0, 0);
      step(1, 0, 1, 0);          // full: dequeue served, enqueue rejected
      for (int i = 0; i < 7; i++) step(0, 0, 1, 0);
      step(1, 0, 1, 0);          // empty: dequeue rejected, enqueue accepted
      step(1, 2, 1, 0);
      step(0, 0, 1, 2);

      // R8: reconfigure a busy queue, with a same-cycle enqueue
      tag = "R8";
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
      cfg_we = 1; cfg_qid = 2'd1; cfg_region = 2'd2; cfg_first = 2'd0; cfg_last = 2'd1;
      enq_valid = 1; enq_qid = 2'd1; enq_data = seq; seq = seq + 16'd1;
      tick();
      for (int i = 0; i < 16; i++) step(1, 1, 0, 0);
      step(1, 1, 0, 0);
      for (int i = 0; i < 16; i++) step(0, 0, 1, 1);

      // R2 / R9: long mixed traffic against the model
      tag = "R9";
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = nextrand();
         step(r[0] | r[1], int'(r[5:4]), r[2] | r[3], int'(r[9:8]));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule